// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Loader

This block is the register front end for four 16-bit converter channels on a shared byte-wide host bus. The host first runs an address cycle. The upper nibble of the address byte picks a board, and the lower nibble picks a starting register. After that, each data strobe reads or writes one byte, and the register pointer advances by one on every strobe.

Software fills a per-channel holding register one byte at a time. The converter-facing output words do not change while this happens. The holding values move to the outputs in one step, on one of two triggers, chosen by a mode bit:

- **Pulse mode:** every pulse of a shared latch line, which a timer elsewhere in the system drives.
- **Software mode:** a write of any value to a dedicated strobe register.

The strobe register sits directly after the last data byte. A full update can therefore be streamed as nine consecutive writes after a single address cycle.

Output codes are offset binary: 0xFFFF is full positive scale, 0x8000 is zero and 0x0000 is full negative scale. A one-cycle load strobe marks every transfer.

Top module: `quad_dac_loader`

## Requirements
- R1: After reset every output word is 0x8000, every holding register is 0x8000, the load strobe is low and the mode bit is 0 (pulse mode).
- R2: An address cycle selects the block only when bus_wdata[7:4] equals BOARD_ID. While the block is not selected, data strobes change nothing and rdata reads 0x00.
- R3: The register pointer is loaded from bus_wdata[3:0] on an address cycle. It advances by one after every data read or data write to the selected block, wrapping from 15 to 0.
- R4: A write to register 2k sets bits 7:0 of channel k's holding value. A write to register 2k+1 sets bits 15:8 (k = 0..3).
- R5: A read of registers 0 to 7 returns the holding byte placed there by R4. A read of register 12 returns the mode in bit 0 with bits 7:1 zero. A read of any other register returns 0x00.
- R6: In pulse mode, a latch_pulse copies all four holding values to dac_codes (channel k in bits 16k+15:16k) on the next clock edge, and load_strb is high for exactly that one cycle.
- R7: In software mode, a write of any value to register 8 performs the R6 transfer, and latch_pulse causes no transfer.
- R8: In pulse mode, a write to register 8 causes no transfer.
- R9: Writes to holding registers do not change dac_codes until a transfer takes place.
- R10: A write to register 12 sets the mode from bit 0 of the written byte (1 = software mode). The other bits are ignored.
- R11: Writes to registers 9, 10, 11, 13, 14 and 15 change no holding value, no output and not the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wdata | input | 8 | Host byte: board/register address on an address cycle, data on a write |
| addr_stb | input | 1 | Address cycle strobe, one cycle per byte |
| data_wr | input | 1 | Data write strobe, one cycle per byte |
| data_rd | input | 1 | Data read strobe, one cycle per byte |
| latch_pulse | input | 1 | Shared timer latch pulse |
| rdata | output | 8 | Read data for the current pointer (combinational) |
| load_strb | output | 1 | High for the cycle in which new output words first appear |
| dac_codes | output | 64 | Four 16-bit offset-binary output words, channel 0 in the low bits |

## Verification
Each kind of wrong internal state reaches the ports at a known point:

- **Pointer:** an off-by-one pointer sends the next byte to a neighbouring register. This shows up on the next readback, and on the outputs at the next transfer.
- **Mode bit:** a stuck mode bit shows as an extra or missing load strobe on the very next latch pulse or strobe-register write.
- **Holding bytes:** holding registers are invisible on dac_codes until a transfer. The bench therefore reads every byte back before triggering one, which exposes a corrupt byte within one read.
- **Double buffering:** a leak through the double buffer changes dac_codes one cycle after the data write itself.

// File: rtl/quad_dac_loader.sv
module quad_dac_loader #(
  parameter int          NCH       = 4,
  parameter int          CW        = 16,
  parameter logic [3:0]  BOARD_ID  = 4'h0,
  parameter logic [3:0]  MODE_ADDR = 4'd12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_wdata,
  input  logic              addr_stb,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              latch_pulse,
  output logic [7:0]        rdata,
  output logic              load_strb,
  output logic [NCH*CW-1:0] dac_codes
);
  localparam int         BPC       = CW / 8;
  localparam int         NBYTES    = NCH * BPC;
  localparam int         IW        = $clog2(NBYTES);
  localparam logic [3:0] XFER_ADDR = 4'(NBYTES);
  localparam logic [CW-1:0] MID    = {1'b1, {(CW-1){1'b0}}};

  logic              sel_q;
  logic [3:0]        ptr_q;
  logic              mode_q;
  logic [7:0]        hold_b [NBYTES];
  logic [NCH*CW-1:0] hold_flat;

  wire wr_hit = sel_q && data_wr && !addr_stb;
  wire rd_hit = sel_q && data_rd && !data_wr && !addr_stb;
  wire xfer   = mode_q ? (wr_hit && ptr_q == XFER_ADDR) : latch_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      ptr_q <= '0;
    end else if (addr_stb) begin
      sel_q <= (bus_wdata[7:4] == BOARD_ID);
      ptr_q <= bus_wdata[3:0];
    end else if (wr_hit || rd_hit) begin
      ptr_q <= ptr_q + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           mode_q <= 1'b0;
    else if (wr_hit && ptr_q == MODE_ADDR) mode_q <= bus_wdata[0];
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)                        hold_b[b] <= MID[(b % BPC)*8 +: 8];
      else if (wr_hit && ptr_q == 4'(b)) hold_b[b] <= bus_wdata;
    end
    assign hold_flat[b*8 +: 8] = hold_b[b];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_codes <= {NCH{MID}};
      load_strb <= 1'b0;
    end else begin
      load_strb <= xfer;
      if (xfer) dac_codes <= hold_flat;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (sel_q) begin
      if (ptr_q < XFER_ADDR)       rdata = hold_b[ptr_q[IW-1:0]];
      else if (ptr_q == MODE_ADDR) rdata = {7'b0, mode_q};
    end
  end
endmodule

// File: rtl/quad_dac_loader_chk.sv
module quad_dac_loader_chk #(
  parameter int         NCH      = 4,
  parameter int         CW       = 16,
  parameter logic [3:0] BOARD_ID = 4'h0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_stb,
  input logic              data_wr,
  input logic              latch_pulse,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        rdata,
  input logic              load_strb,
  input logic [NCH*CW-1:0] dac_codes,
  input logic [NCH*CW-1:0] hold_flat,
  input logic              mode_q
);
  AST_CODES_HOLD_BETWEEN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_strb |-> $stable(dac_codes)); // R9
  AST_LOAD_COPIES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_strb |-> dac_codes == $past(hold_flat)); // R6
  AST_SW_LOAD_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    load_strb && !$past(latch_pulse) |-> $past(mode_q)); // R7
  AST_PULSE_IGNORED_IN_SW: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q && latch_pulse && !data_wr |=> !load_strb); // R7
  AST_NO_LOAD_WITHOUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q && !latch_pulse |=> !load_strb); // R8
  AST_DESELECT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb && bus_wdata[7:4] != BOARD_ID |=> rdata == 8'h00); // R2
endmodule

bind quad_dac_loader quad_dac_loader_chk #(.NCH(NCH), .CW(CW), .BOARD_ID(BOARD_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_stb(addr_stb), .data_wr(data_wr),
  .latch_pulse(latch_pulse), .bus_wdata(bus_wdata), .rdata(rdata),
  .load_strb(load_strb), .dac_codes(dac_codes), .hold_flat(hold_flat), .mode_q(mode_q));

// File: tb/quad_dac_loader_test.sv
module quad_dac_loader_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic addr_stb = 1'b0, data_wr = 1'b0, data_rd = 1'b0, latch_pulse = 1'b0;
  logic [7:0] rdata;
  logic load_strb;
  logic [63:0] dac_codes;
  int vectors = 0, fails = 0;

  logic [7:0]  m_hold [8];
  logic [63:0] m_out;
  logic        m_mode, m_sel, m_strb;
  logic [3:0]  m_ptr;

  always #2 clk = ~clk;

  quad_dac_loader uut (.clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata), .addr_stb(addr_stb),
    .data_wr(data_wr), .data_rd(data_rd), .latch_pulse(latch_pulse), .rdata(rdata),
    .load_strb(load_strb), .dac_codes(dac_codes));

  function automatic logic [63:0] packed_hold();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = m_hold[i];
    return v;
  endfunction

  function automatic logic [7:0] rd_exp();
    if (!m_sel) return 8'h00;
    if (m_ptr < 4'd8) return m_hold[m_ptr[2:0]];
    if (m_ptr == 4'd12) return {7'b0, m_mode};
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input string tag, input logic a, input logic w, input logic r,
                    input logic l, input logic [7:0] d);
    logic xf;
    @(negedge clk);
    addr_stb = a; data_wr = w; data_rd = r; latch_pulse = l; bus_wdata = d;
    #1;
    if (r && !a && !w) chk({tag, " read"}, {56'b0, rdata}, {56'b0, rd_exp()});
    @(posedge clk);
    #1;
    addr_stb = 0; data_wr = 0; data_rd = 0; latch_pulse = 0;
    xf = m_mode ? (w && m_sel && !a && m_ptr == 4'd8) : l;
    if (xf) m_out = packed_hold();
    m_strb = xf;
    if (a) begin
      m_sel = (d[7:4] == 4'h0); m_ptr = d[3:0];
    end else if (w && m_sel) begin
      if (m_ptr < 4'd8) m_hold[m_ptr[2:0]] = d;
      if (m_ptr == 4'd12) m_mode = d[0];
      m_ptr = m_ptr + 4'd1;
    end else if (r && m_sel) begin
      m_ptr = m_ptr + 4'd1;
    end
    chk({tag, " codes"}, dac_codes, m_out);
    chk({tag, " strobe"}, {63'b0, load_strb}, {63'b0, m_strb});
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7345));
    for (int i = 0; i < 8; i++) m_hold[i] = (i % 2) ? 8'h80 : 8'h00;
    m_out = {4{16'h8000}}; m_mode = 0; m_sel = 0; m_ptr = 0; m_strb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R1 reset codes", dac_codes, {4{16'h8000}});
    chk("R1 reset strobe", {63'b0, load_strb}, 64'b0);
    chk("R2 unselected rdata", {56'b0, rdata}, 64'h0);
    op("R1 mode select", 1, 0, 0, 0, 8'h0C);
    op("R1 mode reset", 0, 0, 1, 0, 8'h00);
    // R2: other board selected, writes and reads have no effect
    op("R2 other board", 1, 0, 0, 0, 8'h11);
    op("R2 ignored write", 0, 1, 0, 0, 8'h55);
    op("R2 ignored read", 0, 0, 1, 0, 8'h00);
    op("R2 reselect", 1, 0, 0, 0, 8'h01);
    op("R2 hold intact", 0, 0, 1, 0, 8'h00);
    // R3 R4 R9: stream eight bytes, outputs unchanged
    op("R3 select 0", 1, 0, 0, 0, 8'h00);
    for (int i = 0; i < 8; i++) op("R4 R9 byte write", 0, 1, 0, 0, 8'(8'h11 * (i + 1)));
    op("R5 select 0", 1, 0, 0, 0, 8'h00);
    for (int i = 0; i < 16; i++) op("R5 readback", 0, 0, 1, 0, 8'h00);
    op("R6 latch pulse", 0, 0, 0, 1, 8'h00);
    op("R6 strobe drops", 0, 0, 0, 0, 8'h00);
    op("R8 select 8", 1, 0, 0, 0, 8'h08);
    op("R8 pulse mode strobe write", 0, 1, 0, 0, 8'hA5);
    op("R10 select 12", 1, 0, 0, 0, 8'h0C);
    op("R10 even byte", 0, 1, 0, 0, 8'hFE);
    op("R10 select 12", 1, 0, 0, 0, 8'h0C);
    op("R10 read mode 0", 0, 0, 1, 0, 8'h00);
    op("R10 select 12", 1, 0, 0, 0, 8'h0C);
    op("R10 set sw mode", 0, 1, 0, 0, 8'h01);
    op("R10 select 12", 1, 0, 0, 0, 8'h0C);
    op("R10 read mode 1", 0, 0, 1, 0, 8'h00);
    op("R7 pulse ignored", 0, 0, 0, 1, 8'h00);
    op("R7 select 6", 1, 0, 0, 0, 8'h06);
    op("R7 ch3 low", 0, 1, 0, 0, 8'h00);
    op("R7 ch3 high", 0, 1, 0, 0, 8'hFF);
    op("R7 sw strobe", 0, 1, 0, 0, 8'h3C);
    // R11: writes to unused registers
    op("R11 select 9", 1, 0, 0, 0, 8'h09);
    for (int i = 0; i < 7; i++) op("R11 unused write", 0, 1, 0, 0, (i == 3) ? 8'h01 : 8'h00);
    op("R11 select 13", 1, 0, 0, 0, 8'h0D);
    op("R11 write 13", 0, 1, 0, 0, 8'h00);
    op("R11 select 9", 1, 0, 0, 0, 8'h09);
    for (int i = 0; i < 7; i++) op("R11 unused read", 0, 0, 1, 0, 8'h00);
    op("R11 select 0", 1, 0, 0, 0, 8'h00);
    for (int i = 0; i < 8; i++) op("R11 hold intact", 0, 0, 1, 0, 8'h00);
    op("R3 select 15", 1, 0, 0, 0, 8'h0F);
    op("R3 wrap write", 0, 1, 0, 0, 8'h77);
    op("R3 wrap read", 0, 0, 1, 0, 8'h00);
    for (int n = 0; n < 600; n++) begin
      int k;
      logic a, w, r, l;
      logic [7:0] d;
      k = int'($urandom % 16);
      a = (k == 0); w = (k >= 1 && k <= 8); r = (k >= 9);
      l = ($urandom % 6) == 0;
      d = 8'($urandom);
      if (a) d[7:4] = (($urandom % 4) == 0) ? 4'h2 : 4'h0;
      op("R3 R6 R7 random", a, w, r, l, d);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule